// File: doc/BRIEF.md
# Coprocessor Dialog Response Sequencer

This block is the slave-side controller behind a coprocessor's command and response registers. A host processor writes a command word. The block decodes the instruction class from that word and then offers a series of 16-bit response primitives, which the host reads one at a time: a program-counter transfer request, an operand transfer request, an idle/null word, and a release word that frees the host. The host carries out each requested action through dedicated strobes: one for an operand-register access and one for a program-counter write.

The block counts operand accesses against a length field in the command. A down-counter stands in for execution time before the final release is offered. The block also watches the host for dialog errors: a skipped program-counter transfer, a skipped final read, a stray strobe, a malformed command, or a response read that comes too soon after the previous instruction's last operand. Any of these sets a sticky violation flag. While the flag is set, the response register shows a fixed violation word and every host action is ignored until a clear pulse arrives.

Top module: `cop_dialog_seq`

## Requirements
- R1: After reset the response word is the null primitive 0x0802, `viol` is 0 and `busy` is 0.
- R2: A command with class field cmd_data[15:13]=000 and `exc_en`=0 makes the response the release primitive 0x0900. A response read of that word returns the block to null.
- R3: A class-000 command with `exc_en`=1 makes the response 0x8900, the program-counter request with bit 15 set. A read of it turns the response to null. A following `pc_wr` turns it to release.
- R4: A command write while a program-counter request is pending, whether before or after the request was read, sets `viol`.
- R5: A command with class 010 or 011 makes the response the transfer primitive 0x1500, with bit 15 equal to the come-again bit cmd_data[12]. A read of it turns the response to null.
- R6: The size field cmd_data[1:0] (01, 10, 11) gives the number of `opnd_acc` strobes required. The response stays null until the last of these strobes.
- R7: With come-again set, after the last operand access the response is null and `busy` is 1 for exactly EXEC_CYC cycles, and then the response is release. A command write before that release is read sets `viol`.
- R8: With come-again clear, the block is idle right after the last operand access, and a new command is accepted without a final read.
- R9: A response read that is not the final read of a come-again dialog sets `viol` if it comes fewer than MIN_GAP cycles after the last operand access. A read exactly MIN_GAP cycles after is accepted.
- R10: An `opnd_acc` strobe outside an operand transfer, or a `pc_wr` strobe outside a read program-counter request, sets `viol`.
- R11: A command with an unknown class, with size 00 for class 010 or 011, or with any nonzero bit in cmd_data[11:2], sets `viol`.
- R12: `viol` is sticky. While it is set the response is 0x1D0E and host strobes have no effect. A `viol_clr` pulse clears it and leaves the response null.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command-word write strobe |
| cmd_data | input | 16 | Command word |
| resp_rd | input | 1 | Response-register read strobe |
| resp_data | output | 16 | Current response primitive |
| opnd_acc | input | 1 | Operand-register access strobe |
| pc_wr | input | 1 | Program-counter register write strobe |
| exc_en | input | 1 | Any arithmetic exception enable is set |
| viol_clr | input | 1 | Clears the violation flag |
| viol | output | 1 | Sticky protocol-violation flag |
| busy | output | 1 | Execution stand-in counter is running |

## Verification
The bench builds the block with EXEC_CYC=4, MIN_GAP=3 and the gap check enabled. The short execution wait lets the bench count every null cycle before release and compare the count with the parameter directly. A three-cycle gap puts both edges of the timing rule within reach: the bench issues a read two cycles after the last operand access, which must trip the flag, and a read three cycles after, which must pass. All three size codes are run, and both come-again settings are paired with the class-010 dialog.

// File: rtl/cds_pkg.sv
package cds_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REL,
      ST_PCREQ,
      ST_PCWAIT,
      ST_XREQ,
      ST_XFER,
      ST_FIN
   } cds_state_e;

   typedef enum logic [1:0] {
      CL_RR,
      CL_ER,
      CL_RE,
      CL_BAD
   } cds_class_e;

endpackage

// File: rtl/cds_decode.sv
module cds_decode
   import cds_pkg::*;
#(
   parameter int          DW     = 16,
   parameter int          CLS_W  = 3,
   parameter int          SIZE_W = 2,
   parameter logic [CLS_W-1:0] CLS_RR = 3'b000,
   parameter logic [CLS_W-1:0] CLS_ER = 3'b010,
   parameter logic [CLS_W-1:0] CLS_RE = 3'b011
) (
   input  logic [DW-1:0]     cmd_data,
   output cds_class_e        cmd_cls,
   output logic              cmd_ca,
   output logic [SIZE_W-1:0] cmd_size,
   output logic              cmd_bad
);

   localparam int CA_POS = DW - CLS_W - 1;

   logic [CLS_W-1:0]         cls_f;
   logic [CA_POS-SIZE_W-1:0] rsv_f;

   assign cls_f    = cmd_data[DW-1 -: CLS_W];
   assign cmd_ca   = cmd_data[CA_POS];
   assign rsv_f    = cmd_data[CA_POS-1:SIZE_W];
   assign cmd_size = cmd_data[SIZE_W-1:0];

   always_comb begin
      if (cls_f == CLS_RR)      cmd_cls = CL_RR;
      else if (cls_f == CLS_ER) cmd_cls = CL_ER;
      else if (cls_f == CLS_RE) cmd_cls = CL_RE;
      else                      cmd_cls = CL_BAD;
   end

   always_comb begin
      cmd_bad = 1'b0;
      if (cmd_cls == CL_BAD) cmd_bad = 1'b1;
      if (cmd_cls != CL_RR && cmd_size == '0) cmd_bad = 1'b1;
      if (|rsv_f) cmd_bad = 1'b1;
   end

endmodule

// File: rtl/cds_count.sv
module cds_count #(
   parameter int SIZE_W       = 2,
   parameter int EXEC_CYC     = 16,
   parameter int MIN_GAP      = 3,
   parameter bit GAP_CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SIZE_W-1:0] size_in,
   input  logic              acc_ok,
   output logic              last,
   output logic              busy,
   output logic              gap_open
);

   localparam int EW = $clog2(EXEC_CYC + 1);
   localparam logic [SIZE_W-1:0] ONE = SIZE_W'(1);

   logic [SIZE_W-1:0] cnt_q;
   logic [SIZE_W-1:0] size_q;
   logic [EW-1:0]     exec_q;
   logic              fin_evt;

   assign last    = (cnt_q + ONE) == size_q;
   assign fin_evt = acc_ok && last;
   assign busy    = exec_q != '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         size_q <= '0;
      end else if (start) begin
         cnt_q  <= '0;
         size_q <= size_in;
      end else if (acc_ok) begin
         cnt_q  <= last ? '0 : cnt_q + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       exec_q <= '0;
      else if (fin_evt) exec_q <= EW'(EXEC_CYC);
      else if (busy)    exec_q <= exec_q - 1'b1;
   end

   AST_BUSY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      fin_evt |=> busy); // R7

   generate
      if (GAP_CHECK_EN) begin : g_gap
         localparam int GW = $clog2(MIN_GAP + 1);
         logic [GW-1:0] gap_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         gap_q <= '0;
            else if (fin_evt)   gap_q <= GW'(MIN_GAP - 1);
            else if (gap_q != '0) gap_q <= gap_q - 1'b1;
         end

         assign gap_open = gap_q != '0;

         if (MIN_GAP > 1) begin : g_gap_chk
            AST_GAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
               fin_evt |=> gap_open); // R9
         end
      end else begin : g_nogap
         assign gap_open = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cds_fsm.sv
module cds_fsm
   import cds_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr,
   input  logic       resp_rd,
   input  logic       opnd_acc,
   input  logic       pc_wr,
   input  logic       viol_clr,
   input  logic       exc_en,
   input  cds_class_e cmd_cls,
   input  logic       cmd_ca,
   input  logic       cmd_bad,
   input  logic       last,
   input  logic       busy,
   input  logic       gap_open,
   output cds_state_e state,
   output logic       ca_q,
   output logic       start,
   output logic       acc_ok,
   output logic       viol
);

   cds_state_e nxt;
   logic       ca_nxt;
   logic       ev_bad;

   always_comb begin
      nxt    = state;
      ca_nxt = ca_q;
      ev_bad = 1'b0;
      acc_ok = 1'b0;
      start  = 1'b0;
      if (!viol) begin
         unique case (state)
            ST_IDLE, ST_REL: begin
               if (resp_rd && state == ST_REL) nxt = ST_IDLE;
               if (cmd_wr) begin
                  if (cmd_bad) begin
                     ev_bad = 1'b1;
                  end else begin
                     start  = 1'b1;
                     ca_nxt = cmd_ca;
                     if (cmd_cls == CL_RR) nxt = exc_en ? ST_PCREQ : ST_REL;
                     else                  nxt = ST_XREQ;
                  end
               end
            end
            ST_PCREQ: begin
               if (cmd_wr)       ev_bad = 1'b1;
               else if (resp_rd) nxt = ST_PCWAIT;
            end
            ST_PCWAIT: begin
               if (cmd_wr)     ev_bad = 1'b1;
               else if (pc_wr) nxt = ST_REL;
            end
            ST_XREQ: begin
               if (cmd_wr)       ev_bad = 1'b1;
               else if (resp_rd) nxt = ST_XFER;
            end
            ST_XFER: begin
               if (cmd_wr) begin
                  ev_bad = 1'b1;
               end else if (opnd_acc) begin
                  acc_ok = 1'b1;
                  if (last) nxt = ca_q ? ST_FIN : ST_IDLE;
               end
            end
            ST_FIN: begin
               if (cmd_wr)                ev_bad = 1'b1;
               else if (resp_rd && !busy) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
         endcase
         if (opnd_acc && state != ST_XFER)             ev_bad = 1'b1;
         if (pc_wr && state != ST_PCWAIT)              ev_bad = 1'b1;
         if (resp_rd && gap_open && state != ST_FIN)   ev_bad = 1'b1;
         if (ev_bad) begin
            nxt    = ST_IDLE;
            acc_ok = 1'b0;
            start  = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         ca_q  <= 1'b0;
         viol  <= 1'b0;
      end else begin
         state <= nxt;
         ca_q  <= ca_nxt;
         viol  <= viol_clr ? 1'b0 : (viol | ev_bad);
      end
   end

   AST_PC_BEFORE_REL: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REL && $past(state) == ST_PCWAIT) |-> $past(pc_wr)); // R3

   AST_PC_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_PCREQ || state == ST_PCWAIT) && cmd_wr && !viol_clr) |=> viol); // R4

   AST_GAP_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_rd && gap_open && state != ST_FIN && !viol_clr) |=> viol); // R9

   AST_STRAY_OPND: assert property (@(posedge clk) disable iff (!rst_n)
      (opnd_acc && state != ST_XFER && !viol_clr) |=> viol); // R10

   AST_VIOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (viol && !viol_clr) |=> viol); // R12

   AST_VIOL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      viol_clr |=> !viol); // R12

   AST_VIOL_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> state == ST_IDLE); // R12

endmodule

// File: rtl/cop_dialog_seq.sv
module cop_dialog_seq
   import cds_pkg::*;
#(
   parameter int          DW           = 16,
   parameter int          CLS_W        = 3,
   parameter int          SIZE_W       = 2,
   parameter int          EXEC_CYC     = 16,
   parameter int          MIN_GAP      = 3,
   parameter bit          GAP_CHECK_EN = 1'b1,
   parameter int          RESP_CA_BIT  = 15,
   parameter logic [DW-1:0] PRIM_NULL  = 16'h0802,
   parameter logic [DW-1:0] PRIM_PCREQ = 16'h8900,
   parameter logic [DW-1:0] PRIM_XFER  = 16'h1500,
   parameter logic [DW-1:0] PRIM_REL   = 16'h0900,
   parameter logic [DW-1:0] PRIM_VIOL  = 16'h1D0E
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_wr,
   input  logic [DW-1:0] cmd_data,
   input  logic          resp_rd,
   output logic [DW-1:0] resp_data,
   input  logic          opnd_acc,
   input  logic          pc_wr,
   input  logic          exc_en,
   input  logic          viol_clr,
   output logic          viol,
   output logic          busy
);

   generate
      if (DW - CLS_W - 2 < SIZE_W) begin : g_bad_fields
         $error("command word too narrow for class, come-again and size fields");
      end
      if (RESP_CA_BIT >= DW) begin : g_bad_cabit
         $error("response come-again bit outside the word");
      end
      if (EXEC_CYC < 1 || MIN_GAP < 1) begin : g_bad_timing
         $error("EXEC_CYC and MIN_GAP must be at least 1");
      end
   endgenerate

   cds_class_e        cmd_cls;
   logic              cmd_ca;
   logic [SIZE_W-1:0] cmd_size;
   logic              cmd_bad;
   cds_state_e        st;
   logic              ca_q;
   logic              start;
   logic              acc_ok;
   logic              last;
   logic              gap_open;

   cds_decode #(
      .DW     (DW),
      .CLS_W  (CLS_W),
      .SIZE_W (SIZE_W)
   ) u_decode (
      .cmd_data (cmd_data),
      .cmd_cls  (cmd_cls),
      .cmd_ca   (cmd_ca),
      .cmd_size (cmd_size),
      .cmd_bad  (cmd_bad)
   );

   cds_count #(
      .SIZE_W       (SIZE_W),
      .EXEC_CYC     (EXEC_CYC),
      .MIN_GAP      (MIN_GAP),
      .GAP_CHECK_EN (GAP_CHECK_EN)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .size_in  (cmd_size),
      .acc_ok   (acc_ok),
      .last     (last),
      .busy     (busy),
      .gap_open (gap_open)
   );

   cds_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (cmd_wr),
      .resp_rd  (resp_rd),
      .opnd_acc (opnd_acc),
      .pc_wr    (pc_wr),
      .viol_clr (viol_clr),
      .exc_en   (exc_en),
      .cmd_cls  (cmd_cls),
      .cmd_ca   (cmd_ca),
      .cmd_bad  (cmd_bad),
      .last     (last),
      .busy     (busy),
      .gap_open (gap_open),
      .state    (st),
      .ca_q     (ca_q),
      .start    (start),
      .acc_ok   (acc_ok),
      .viol     (viol)
   );

   logic [DW-1:0] xfer_word;

   always_comb begin
      xfer_word              = PRIM_XFER;
      xfer_word[RESP_CA_BIT] = ca_q;
   end

   always_comb begin
      if (viol) begin
         resp_data = PRIM_VIOL;
      end else begin
         unique case (st)
            ST_REL:   resp_data = PRIM_REL;
            ST_PCREQ: resp_data = PRIM_PCREQ;
            ST_XREQ:  resp_data = xfer_word;
            ST_FIN:   resp_data = busy ? PRIM_NULL : PRIM_REL;
            default:  resp_data = PRIM_NULL;
         endcase
      end
   end

   AST_FIN_NULL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FIN && busy && !viol) |-> resp_data == PRIM_NULL); // R7

   AST_VIOL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> resp_data == PRIM_VIOL); // R12

endmodule

// File: tb/cop_dialog_seq_bench.sv
module cop_dialog_seq_bench;

   localparam int EXEC = 4;
   localparam int GAP  = 3;
   localparam logic [15:0] P_NULL = 16'h0802;
   localparam logic [15:0] P_PC   = 16'h8900;
   localparam logic [15:0] P_XFER = 16'h1500;
   localparam logic [15:0] P_REL  = 16'h0900;
   localparam logic [15:0] P_VIOL = 16'h1D0E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [15:0] cmd_data = '0;
   logic        resp_rd = 1'b0;
   logic [15:0] resp_data;
   logic        opnd_acc = 1'b0;
   logic        pc_wr = 1'b0;
   logic        exc_en = 1'b0;
   logic        viol_clr = 1'b0;
   logic        viol;
   logic        busy;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   cop_dialog_seq #(
      .EXEC_CYC (EXEC),
      .MIN_GAP  (GAP)
   ) u_cop_dialog_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .cmd_data  (cmd_data),
      .resp_rd   (resp_rd),
      .resp_data (resp_data),
      .opnd_acc  (opnd_acc),
      .pc_wr     (pc_wr),
      .exc_en    (exc_en),
      .viol_clr  (viol_clr),
      .viol      (viol),
      .busy      (busy)
   );

   function automatic logic [15:0] mk(input logic [2:0] cls, input logic ca, input logic [1:0] sz);
      return {cls, ca, 10'd0, sz};
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic c, input logic [15:0] d, input logic r,
                      input logic o, input logic p, input logic x);
      cmd_wr = c; cmd_data = d; resp_rd = r; opnd_acc = o; pc_wr = p; viol_clr = x;
      @(negedge clk);
      cmd_wr = 0; cmd_data = '0; resp_rd = 0; opnd_acc = 0; pc_wr = 0; viol_clr = 0;
   endtask

   task automatic cmd(input logic [15:0] d); cyc(1, d, 0, 0, 0, 0); endtask
   task automatic rd();  cyc(0, '0, 1, 0, 0, 0); endtask
   task automatic opn(); cyc(0, '0, 0, 1, 0, 0); endtask
   task automatic pcw(); cyc(0, '0, 0, 0, 1, 0); endtask
   task automatic clr(); cyc(0, '0, 0, 0, 0, 1); endtask
   task automatic idle(); cyc(0, '0, 0, 0, 0, 0); endtask

   task automatic expect_viol(input string tag);
      chk({tag, " viol"}, {15'd0, viol}, 16'd1);
      chk({tag, " R12 word"}, resp_data, P_VIOL);
      clr();
      chk({tag, " R12 cleared"}, {15'd0, viol}, 16'd0);
      chk({tag, " R12 null after clear"}, resp_data, P_NULL);
   endtask

   task automatic t_reset();
      chk("R1 resp", resp_data, P_NULL);
      chk("R1 viol", {15'd0, viol}, 16'd0);
      chk("R1 busy", {15'd0, busy}, 16'd0);
   endtask

   task automatic t_rr_plain();
      exc_en = 0;
      cmd(mk(3'b000, 0, 2'b00));
      chk("R2 release", resp_data, P_REL);
      rd();
      chk("R2 idle", resp_data, P_NULL);
      chk("R2 viol", {15'd0, viol}, 16'd0);
   endtask

   task automatic t_rr_pc();
      exc_en = 1;
      cmd(mk(3'b000, 0, 2'b00));
      chk("R3 pc request", resp_data, P_PC);
      rd();
      chk("R3 null after read", resp_data, P_NULL);
      pcw();
      chk("R3 release", resp_data, P_REL);
      rd();
      chk("R3 idle", resp_data, P_NULL);
      chk("R3 viol", {15'd0, viol}, 16'd0);
      exc_en = 0;
   endtask

   task automatic t_pc_ignored();
      exc_en = 1;
      cmd(mk(3'b000, 0, 2'b00));
      rd();
      cmd(mk(3'b000, 0, 2'b00));
      expect_viol("R4 after read");
      cmd(mk(3'b000, 0, 2'b00));
      cmd(mk(3'b000, 0, 2'b00));
      expect_viol("R4 unread");
      exc_en = 0;
   endtask

   task automatic t_ext(input logic [2:0] cls, input int sz, input logic ca);
      int n;
      cmd(mk(cls, ca, 2'(sz)));
      chk("R5 transfer word", resp_data, P_XFER | {ca, 15'd0});
      rd();
      chk("R5 null after read", resp_data, P_NULL);
      for (int i = 0; i < sz; i++) begin
         chk("R6 null before last access", resp_data, P_NULL);
         opn();
      end
      if (ca) begin
         n = 0;
         while (resp_data == P_NULL && n < 50) begin
            chk("R7 busy while waiting", {15'd0, busy}, 16'd1);
            n++;
            @(negedge clk);
         end
         chk("R7 wait length", 16'(n), 16'(EXEC));
         chk("R7 release", resp_data, P_REL);
         rd();
         chk("R7 idle", resp_data, P_NULL);
      end else begin
         chk("R8 idle at once", resp_data, P_NULL);
         repeat (GAP) idle();
      end
      chk("R6 no violation", {15'd0, viol}, 16'd0);
   endtask

   task automatic t_fin_skip();
      cmd(mk(3'b010, 1, 2'b01));
      rd();
      opn();
      cmd(mk(3'b000, 0, 2'b00));
      expect_viol("R7 final read skipped");
   endtask

   task automatic t_gap_short();
      cmd(mk(3'b010, 0, 2'b01));
      rd();
      opn();
      cmd(mk(3'b000, 0, 2'b00));
      chk("R9 release offered", resp_data, P_REL);
      rd();
      expect_viol("R9 read two cycles after");
   endtask

   task automatic t_gap_ok();
      cmd(mk(3'b010, 0, 2'b10));
      rd();
      opn();
      opn();
      cmd(mk(3'b000, 0, 2'b00));
      chk("R8 new command accepted", resp_data, P_REL);
      idle();
      rd();
      chk("R9 read at the limit", {15'd0, viol}, 16'd0);
      chk("R9 idle", resp_data, P_NULL);
   endtask

   task automatic t_stray();
      opn();
      expect_viol("R10 stray operand");
      pcw();
      expect_viol("R10 stray pc write");
   endtask

   task automatic t_bad_cmd();
      cmd(mk(3'b111, 0, 2'b01));
      expect_viol("R11 unknown class");
      cmd(mk(3'b010, 1, 2'b00));
      expect_viol("R11 size zero");
      cmd(16'h0010);
      expect_viol("R11 reserved bit");
   endtask

   task automatic t_sticky();
      opn();
      for (int i = 0; i < 3; i++) begin
         chk("R12 held", {15'd0, viol}, 16'd1);
         cmd(mk(3'b000, 0, 2'b00));
      end
      chk("R12 command ignored", resp_data, P_VIOL);
      rd();
      chk("R12 read ignored", resp_data, P_VIOL);
      clr();
      chk("R12 clear to null", resp_data, P_NULL);
      chk("R12 clear flag", {15'd0, viol}, 16'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_rr_plain();
      t_rr_pc();
      t_pc_ignored();
      t_ext(3'b010, 1, 1);
      t_ext(3'b010, 2, 0);
      t_ext(3'b011, 3, 1);
      t_ext(3'b011, 2, 0);
      t_fin_skip();
      t_gap_short();
      t_gap_ok();
      t_stray();
      t_bad_cmd();
      t_sticky();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule